// File: doc/BRIEF.md
# FIFO Threshold Offset Register Port

This block holds the two threshold offsets a FIFO's flag logic compares its fill level against: the near-empty offset and the near-full offset. Both are loaded and read back one byte at a time over the FIFO's ordinary 8-bit data lanes. A load-select strobe turns the FIFO's write and read enables into offset-register accesses. With the strobe active, a write-side enable stores the byte on the input lanes. A read-side enable places the next stored byte on the output lanes.

The offsets share one access sequence. The near-empty offset comes first and the near-full offset second, and each is walked from its least significant byte to its most significant byte. The write side and the read side each keep their own position in this sequence. Each position advances only on its own clock and wraps back to the start. The offset width is a parameter, so the length of the sequence depends on it. The offsets are driven out continuously to the flag logic, which treats them as quasi-static.

Top module: `fifo_offset_port`

## Requirements
- R1: Asynchronous reset (rst_n low) loads the near-empty offset with DEF_AE and the near-full offset with DEF_AF. It returns both the write position and the read position to sequence slot 0, and it clears rd_data to 0.
- R2: A byte from wr_data is stored only at a rising wr_clk edge where load_n and wr_en_n are both 0. With load_n at 0 and wr_en_n at 1, nothing is stored and the write position does not move.
- R3: The sequence runs over 2*NB slots, where NB = ceil(OFS_W/8). Slot k with k < NB holds byte k of the near-empty offset. Slot NB+j holds byte j of the near-full offset. Byte 0 is bits 7:0.
- R4: With the default OFS_W of 17, one full pass takes six transfers. Each offset has a middle byte (bits 15:8) between its low byte and its top byte.
- R5: In the top byte of each offset, wr_data bits that lie at or above OFS_W are discarded. Those bits read back as 0; for OFS_W of 17 only bit 0 of the top byte is kept.
- R6: A byte is read only at a rising rd_clk edge where load_n and rd_en_n are both 0. The byte is registered on rd_data and holds until the next such edge.
- R7: Readback walks the same slot order as loading. Each read returns the stored byte of the slot the read position points at.
- R8: The write and read positions are independent. Each one advances by one per access and wraps from slot 2*NB-1 to slot 0.
- R9: While load_n is 1, wr_en_n and rd_en_n have no effect on the offsets, on rd_data or on either position.
- R10: ae_offset and af_offset always show the current stored offset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_n | input | 1 | Offset access select, active low |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 8 | Offset byte to store |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | 8 | Offset byte read back |
| ae_offset | output | OFS_W | Near-empty offset to the flag logic |
| af_offset | output | OFS_W | Near-full offset to the flag logic |

## Verification
Every byte of a load is written as 0xFF-style data with the top lanes set. A design that forgets the top-byte mask then shows nonzero high bits, both in af_offset and on readback. The bench moves the two positions apart, for example two writes before one read. A design that shares a single pointer, or that advances it on the wrong clock, then returns the wrong slot. The bench also writes past the last near-full byte. A design with an off-by-one wrap then overwrites the near-full offset instead of the low near-empty byte. The bench also pulses the enables with the strobe inactive, and holds the strobe active with the enable inactive. A design that decodes only one of the two signals then corrupts an offset or skips a slot.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    localparam int LANE_W = 8;

    typedef logic [LANE_W-1:0] lane_t;

    // number of byte lanes needed for an offset of width w
    function automatic int lanes_for(input int w);
        return (w + LANE_W - 1) / LANE_W;
    endfunction

    // bits of lane idx that belong to a w-bit offset
    function automatic lane_t lane_mask(input int w, input int idx);
        int keep;
        keep = w - idx * LANE_W;
        if (keep >= LANE_W) begin
            return '1;
        end else if (keep <= 0) begin
            return '0;
        end else begin
            return lane_t'((1 << keep) - 1);
        end
    endfunction

endpackage

// File: rtl/ofs_slot_ptr.sv
module ofs_slot_ptr #(
    parameter int NSLOTS = 6,
    parameter int PTR_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NSLOTS - 1);

    typedef struct packed {
        logic [PTR_W-1:0] pos;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (st_q.pos == LAST) begin
                st_d.pos = '0;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.pos;

endmodule

// File: rtl/ofs_store.sv
module ofs_store
    import ofs_pkg::*;
#(
    parameter int                OFS_W  = 17,
    parameter int                NSLOTS = 6,
    parameter int                PTR_W  = 3,
    parameter logic [OFS_W-1:0]  DEF_AE = '0,
    parameter logic [OFS_W-1:0]  DEF_AF = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_fire,
    input  logic [PTR_W-1:0]         ptr,
    input  lane_t                    wr_data,
    output lane_t [NSLOTS-1:0]       slots
);
    localparam int NB   = NSLOTS / 2;
    localparam int SPAN = NB * LANE_W;
    localparam logic [2*SPAN-1:0] RST_IMAGE = {SPAN'(DEF_AF), SPAN'(DEF_AE)};

    typedef struct packed {
        lane_t [NSLOTS-1:0] slot;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NSLOTS; k++) begin
            if (wr_fire && (ptr == PTR_W'(k))) begin
                st_d.slot[k] = wr_data & lane_mask(OFS_W, k % NB);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.slot <= RST_IMAGE;
        end else begin
            st_q <= st_d;
        end
    end

    assign slots = st_q.slot;

endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
    import ofs_pkg::*;
#(
    parameter int NSLOTS = 6,
    parameter int PTR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_fire,
    input  logic [PTR_W-1:0]   ptr,
    input  lane_t [NSLOTS-1:0] slots,
    output lane_t              rd_data
);
    typedef struct packed {
        lane_t data;
    } rb_st_t;

    rb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_fire) begin
            st_d.data = '0;
            for (int k = 0; k < NSLOTS; k++) begin
                if (ptr == PTR_W'(k)) begin
                    st_d.data = slots[k];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.data;

endmodule

// File: rtl/fifo_offset_port.sv
module fifo_offset_port
    import ofs_pkg::*;
#(
    parameter int               OFS_W  = 17,
    parameter logic [OFS_W-1:0] DEF_AE = OFS_W'(7),
    parameter logic [OFS_W-1:0] DEF_AF = OFS_W'(7)
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             wr_en_n,
    input  logic [7:0]       wr_data,
    input  logic             rd_en_n,
    output logic [7:0]       rd_data,
    output logic [OFS_W-1:0] ae_offset,
    output logic [OFS_W-1:0] af_offset
);
    localparam int NB     = lanes_for(OFS_W);
    localparam int NSLOTS = 2 * NB;
    localparam int PTR_W  = $clog2(NSLOTS);
    localparam int SPAN   = NB * LANE_W;

    logic               wr_fire;
    logic               rd_fire;
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    lane_t [NSLOTS-1:0] slots;
    logic [2*SPAN-1:0]  image;

    assign wr_fire = !load_n && !wr_en_n;
    assign rd_fire = !load_n && !rd_en_n;

    ofs_slot_ptr #(.NSLOTS(NSLOTS), .PTR_W(PTR_W)) wr_pos_i (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .step  (wr_fire),
        .ptr   (wr_ptr)
    );

    ofs_slot_ptr #(.NSLOTS(NSLOTS), .PTR_W(PTR_W)) rd_pos_i (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .step  (rd_fire),
        .ptr   (rd_ptr)
    );

    ofs_store #(
        .OFS_W  (OFS_W),
        .NSLOTS (NSLOTS),
        .PTR_W  (PTR_W),
        .DEF_AE (DEF_AE),
        .DEF_AF (DEF_AF)
    ) store_i (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .ptr     (wr_ptr),
        .wr_data (wr_data),
        .slots   (slots)
    );

    ofs_readback #(.NSLOTS(NSLOTS), .PTR_W(PTR_W)) readback_i (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .rd_fire (rd_fire),
        .ptr     (rd_ptr),
        .slots   (slots),
        .rd_data (rd_data)
    );

    assign image     = slots;
    assign ae_offset = image[OFS_W-1:0];
    assign af_offset = image[SPAN +: OFS_W];

endmodule

// File: rtl/ofs_port_chk.sv
module ofs_port_chk #(
    parameter int OFS_W  = 17,
    parameter int NSLOTS = 6,
    parameter int PTR_W  = 3
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             wr_en_n,
    input logic             rd_en_n,
    input logic [7:0]       rd_data,
    input logic [OFS_W-1:0] ae_offset,
    input logic [OFS_W-1:0] af_offset,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_ptr
);
    localparam int NB = NSLOTS / 2;
    localparam logic [PTR_W-1:0] LAST    = PTR_W'(NSLOTS - 1);
    localparam logic [PTR_W-1:0] AE_TOP  = PTR_W'(NB - 1);
    localparam logic [PTR_W-1:0] AF_TOP  = PTR_W'(NSLOTS - 1);
    localparam logic [7:0]       TOP_MSK = ofs_pkg::lane_mask(OFS_W, NB - 1);

    // R8
    wr_ptr_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!load_n && !wr_en_n) |=>
        (wr_ptr == (($past(wr_ptr) == LAST) ? '0 : $past(wr_ptr) + 1'b1)));

    // R8
    rd_ptr_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!load_n && !rd_en_n) |=>
        (rd_ptr == (($past(rd_ptr) == LAST) ? '0 : $past(rd_ptr) + 1'b1)));

    // R9
    wr_idle_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (load_n || wr_en_n) |=>
        ($stable(ae_offset) && $stable(af_offset) && $stable(wr_ptr)));

    // R6
    rd_idle_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (load_n || rd_en_n) |=> ($stable(rd_data) && $stable(rd_ptr)));

    // R5
    top_lane_zero_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!load_n && !rd_en_n && (rd_ptr == AE_TOP || rd_ptr == AF_TOP)) |=>
        ((rd_data & ~TOP_MSK) == 8'h00));

    // R3
    ptr_range_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_ptr <= LAST) && (rd_ptr <= LAST));

endmodule

bind fifo_offset_port ofs_port_chk #(
    .OFS_W  (OFS_W),
    .NSLOTS (NSLOTS),
    .PTR_W  (PTR_W)
) chk_i (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .wr_en_n   (wr_en_n),
    .rd_en_n   (rd_en_n),
    .rd_data   (rd_data),
    .ae_offset (ae_offset),
    .af_offset (af_offset),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr)
);

// File: tb/fifo_offset_port_test.sv
module fifo_offset_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = 14;
    localparam int W  = 17;
    localparam int NB = 3;
    localparam logic [W-1:0] AE0 = 17'h1_0A05;
    localparam logic [W-1:0] AF0 = 17'h0_3C2B;

    logic wr_clk = 0, rd_clk = 0, rst_n = 0;
    logic load_n = 1, wr_en_n = 1, rd_en_n = 1;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic [W-1:0] ae_offset, af_offset;

    int tests = 0, fails = 0;
    logic [W-1:0] exp_ae, exp_af;

    always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

    fifo_offset_port #(.OFS_W(W), .DEF_AE(AE0), .DEF_AF(AF0)) uut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .load_n(load_n),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
        .rd_data(rd_data), .ae_offset(ae_offset), .af_offset(af_offset)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] slot_byte(input int k);
        logic [W-1:0] v;
        v = (k < NB) ? exp_ae : exp_af;
        return 8'((v >> (8 * (k % NB))) & 'hFF);
    endfunction

    task automatic do_reset();
        @(negedge wr_clk); rst_n = 0;
        repeat (3) @(negedge wr_clk);
        rst_n = 1;
        exp_ae = AE0; exp_af = AF0;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge wr_clk); load_n = 0; wr_en_n = 0; wr_data = b;
        @(negedge wr_clk); load_n = 1; wr_en_n = 1;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        @(negedge rd_clk); load_n = 0; rd_en_n = 0;
        @(negedge rd_clk); b = rd_data; load_n = 1; rd_en_n = 1;
    endtask

    task automatic t_reset();
        logic [7:0] b;
        check("R1 rd_data after reset", rd_data, 0);
        check("R1 ae default", ae_offset, AE0);
        check("R1 af default", af_offset, AF0);
        for (int k = 0; k < 2*NB; k++) begin
            rd_byte(b);
            check($sformatf("R7 R3 default slot %0d", k), b, slot_byte(k));
        end
    endtask

    task automatic t_full_load();
        logic [7:0] b;
        wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'hFF);
        wr_byte(8'h44); wr_byte(8'h55); wr_byte(8'hFE);
        exp_ae = 17'h1_2211; exp_af = 17'h0_5544;
        check("R4 R5 R10 ae after six writes", ae_offset, exp_ae);
        check("R4 R5 R10 af after six writes", af_offset, exp_af);
        for (int k = 0; k < 2*NB; k++) begin
            rd_byte(b);
            check($sformatf("R7 R5 readback slot %0d", k), b, slot_byte(k));
        end
    endtask

    task automatic t_ignored();
        logic [7:0] held, b;
        held = rd_data;
        repeat (3) begin
            @(negedge wr_clk); load_n = 1; wr_en_n = 0; wr_data = 8'h99;
        end
        @(negedge wr_clk); wr_en_n = 1;
        check("R9 ae with strobe off", ae_offset, exp_ae);
        check("R9 af with strobe off", af_offset, exp_af);
        @(negedge wr_clk); load_n = 0; wr_en_n = 1; wr_data = 8'h77;
        repeat (2) @(negedge wr_clk);
        load_n = 1;
        check("R2 ae with enable off", ae_offset, exp_ae);
        repeat (3) begin
            @(negedge rd_clk); load_n = 1; rd_en_n = 0;
        end
        @(negedge rd_clk); rd_en_n = 1;
        check("R9 rd_data held", rd_data, held);
        rd_byte(b);
        check("R9 read position unmoved", b, slot_byte(0));
        wr_byte(8'h3A);
        exp_ae[7:0] = 8'h3A;
        check("R2 write position unmoved", ae_offset, exp_ae);
        repeat (5) rd_byte(b);
        repeat (5) wr_byte(slot_byte(0) == 8'h3A ? 8'h00 : 8'h00);
        exp_ae = 17'h0_0000; exp_af = 17'h0_0000;
        exp_ae[7:0] = 8'h3A;
        check("R8 ae after realign", ae_offset, exp_ae);
        check("R8 af after realign", af_offset, exp_af);
    endtask

    task automatic t_independent();
        logic [7:0] b;
        wr_byte(8'hA1); wr_byte(8'hA2);
        exp_ae = 17'h0_A2A1;
        rd_byte(b);
        check("R8 read position independent", b, 8'hA1);
        wr_byte(8'hB3); wr_byte(8'hB4); wr_byte(8'hB5); wr_byte(8'hB6);
        exp_ae = 17'h1_A2A1; exp_af = 17'h0_B5B4;
        check("R5 af top lane masked", af_offset, exp_af);
        wr_byte(8'hC7);
        exp_ae = 17'h1_A2C7;
        check("R8 write wraps to slot 0", ae_offset, exp_ae);
        check("R8 wrap leaves af", af_offset, exp_af);
        rd_byte(b);
        check("R8 read continues at slot 1", b, 8'hA2);
        repeat (3) @(negedge rd_clk);
        check("R6 rd_data holds", rd_data, 8'hA2);
    endtask

    task automatic t_mid_reset();
        logic [7:0] b;
        wr_byte(8'h01);
        do_reset();
        check("R1 ae after mid reset", ae_offset, AE0);
        check("R1 af after mid reset", af_offset, AF0);
        check("R1 rd_data after mid reset", rd_data, 0);
        rd_byte(b);
        check("R1 read restarts at slot 0", b, slot_byte(0));
        wr_byte(8'h5C);
        exp_ae[7:0] = 8'h5C;
        check("R1 write restarts at slot 0", ae_offset, exp_ae);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        exp_ae = AE0; exp_af = AF0;
        repeat (3) @(negedge wr_clk);
        rst_n = 1;
        @(negedge wr_clk);
        t_reset();
        t_full_load();
        t_ignored();
        t_independent();
        t_mid_reset();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule